// File: doc/BRIEF.md
# Codec Host Register Bank

This block sits between a byte-wide host bus and the engine that shifts bytes to and from a serial voice codec. The host sees eight byte registers behind a 3-bit address. A write to one of the four low addresses acts only as a strobe: it clears or sets the interrupt mask, or drives the codec reset pin high or low. The written data on those addresses has no effect. A read of address 0 returns a status byte whose top bit is the ready flag. The four upper addresses belong to four byte channels: voice A, voice B, control and signaling.

A host write to a channel address places the byte in that channel's holding register and marks it pending. Pending bytes leave on a valid/ready stream toward the serial engine, and the engine applies back-pressure by holding `tx_ready` low. The receive direction has no back-pressure. Every cycle with `rx_valid` high stores `rx_data` as the channel's last received byte, and the host reads that byte back at the channel's address. The ready flag drops when the host writes the control byte. It rises again when the serial engine pulses `xfer_done`. The interrupt line is the ready flag gated by the mask.

Top module: `codec_host_regs`

## Requirements
- R1: After reset, `host_rdata` is 0, `irq` is 0, `codec_rst` is 1, `tx_valid` is 0, the interrupt mask is 0 and the ready flag is 1.
- R2: A read takes effect on the clock edge where `host_rd` is high. `host_rdata` then shows the addressed value from the following cycle and holds it until the next read. At address 0 bit 7 is the ready flag and bits 6..0 are 0.
- R3: A write to address 0 clears the interrupt mask whatever the data byte is.
- R4: A write to address 1 sets the interrupt mask whatever the data byte is. `irq` equals ready flag AND mask in every cycle after reset.
- R5: A write to address 2 drives `codec_rst` to 1 and a write to address 3 drives it to 0, from the next cycle, whatever the data byte is.
- R6: Reads of addresses 1, 2 and 3 return 0.
- R7: A write to address 6 clears the ready flag. A cycle with `xfer_done` high sets it. If both occur in the same cycle, the flag is cleared.
- R8: A write to address 4+c (channel code c: 0 voice A, 1 voice B, 2 control, 3 signaling) queues the byte for output with `tx_sel` = c. A second write to the same channel before its byte is taken into the output stage replaces the queued byte.
- R9: When several channels are pending, the lowest channel code is sent first.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_sel` and `tx_data` stay unchanged. Each cycle with both high hands over one byte, and the next pending byte is presented in the very next cycle.
- R11: A cycle with `rx_valid` high stores `rx_data` for channel `rx_sel`. A later read of address 4+`rx_sel` returns it. A read in the same cycle as the store returns the older byte.
- R12: The received bytes of all four channels reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | 3 | Host register address |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| irq | output | 1 | Interrupt request, ready flag gated by mask |
| codec_rst | output | 1 | Codec reset pin, high holds the codec powered down |
| tx_valid | output | 1 | Outgoing byte available |
| tx_ready | input | 1 | Serial engine accepts the outgoing byte |
| tx_sel | output | 2 | Channel code of the outgoing byte |
| tx_data | output | 8 | Outgoing byte |
| rx_valid | input | 1 | Incoming byte strobe, always accepted |
| rx_sel | input | 2 | Channel code of the incoming byte |
| rx_data | input | 8 | Incoming byte |
| xfer_done | input | 1 | Serial engine finished a transfer, sets the ready flag |

## Verification
A corrupted mask or ready flag shows on `irq` in the cycle after the access that should have set it. A corrupted ready flag also shows in bit 7 of the next status read. A bad reset-pin register shows on `codec_rst` one cycle after the power strobe. A wrong pending bit or arbitration choice surfaces only when the stream drains: a lost, duplicated or reordered byte appears at `tx_sel`/`tx_data` within as many handshakes as there are queued channels. A wrong receive store stays hidden until the host reads that channel, and then shows one cycle after the read strobe.

// File: rtl/chb_pkg.sv
package chb_pkg;
  localparam int unsigned CH_COUNT = 4;
  localparam int unsigned CH_W     = $clog2(CH_COUNT);
  localparam int unsigned ADDR_W   = CH_W + 1;

  typedef enum logic [CH_W-1:0] {
    CH_VOICE_A = 2'd0,
    CH_VOICE_B = 2'd1,
    CH_CTRL    = 2'd2,
    CH_SIGNAL  = 2'd3
  } chan_e;

  typedef enum logic [ADDR_W-1:0] {
    A_STATUS   = 3'd0,
    A_MASK_SET = 3'd1,
    A_PWR_DOWN = 3'd2,
    A_PWR_UP   = 3'd3,
    A_VOICE_A  = 3'd4,
    A_VOICE_B  = 3'd5,
    A_CTRL     = 3'd6,
    A_SIGNAL   = 3'd7
  } addr_e;
endpackage

// File: rtl/chb_ctrl.sv
module chb_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_mask,
  input  logic set_mask,
  input  logic pwr_down,
  input  logic pwr_up,
  input  logic ctrl_wr,
  input  logic xfer_done,
  output logic ready,
  output logic irq,
  output logic codec_rst
);
  logic mask_q;
  logic ready_q;
  logic rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= 1'b0;
      ready_q <= 1'b1;
      rst_q   <= 1'b1;
    end else begin
      if (clr_mask)      mask_q <= 1'b0;
      else if (set_mask) mask_q <= 1'b1;
      // a control write wins over a simultaneous done strobe
      if (ctrl_wr)        ready_q <= 1'b0;
      else if (xfer_done) ready_q <= 1'b1;
      if (pwr_down)    rst_q <= 1'b1;
      else if (pwr_up) rst_q <= 1'b0;
    end
  end

  assign ready     = ready_q;
  assign irq       = ready_q & mask_q;
  assign codec_rst = rst_q;
endmodule

// File: rtl/chb_tx.sv
module chb_tx #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CH_N   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [$clog2(CH_N)-1:0] wr_ch,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    tx_ready,
  output logic                    tx_valid,
  output logic [$clog2(CH_N)-1:0] tx_sel,
  output logic [DATA_W-1:0]       tx_data
);
  localparam int unsigned SW = $clog2(CH_N);

  logic [CH_N-1:0]   pend;
  logic [DATA_W-1:0] hold [CH_N];
  logic [CH_N-1:0]   grant;
  logic [SW-1:0]     pick;
  logic              any_pend;
  logic              load_en;

  // lowest channel code wins
  always_comb begin
    pick = '0;
    for (int i = CH_N - 1; i >= 0; i--) begin
      if (pend[i]) pick = SW'(i);
    end
  end

  assign any_pend = |pend;
  assign load_en  = any_pend && (!tx_valid || tx_ready);

  for (genvar c = 0; c < CH_N; c++) begin : g_slot
    assign grant[c] = load_en && (pick == SW'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[c] <= 1'b0;
        hold[c] <= '0;
      end else if (wr_en && wr_ch == SW'(c)) begin
        pend[c] <= 1'b1;
        hold[c] <= wr_data;
      end else if (grant[c]) begin
        pend[c] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_sel   <= '0;
      tx_data  <= '0;
    end else if (load_en) begin
      tx_valid <= 1'b1;
      tx_sel   <= pick;
      tx_data  <= hold[pick];
    end else if (tx_ready) begin
      tx_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/chb_rx.sv
module chb_rx #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CH_N   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rx_valid,
  input  logic [$clog2(CH_N)-1:0] rx_sel,
  input  logic [DATA_W-1:0]       rx_data,
  input  logic [$clog2(CH_N)-1:0] rd_ch,
  output logic [DATA_W-1:0]       rd_byte
);
  localparam int unsigned SW = $clog2(CH_N);

  logic [DATA_W-1:0] last [CH_N];

  for (genvar c = 0; c < CH_N; c++) begin : g_store
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              last[c] <= '0;
      else if (rx_valid && rx_sel == SW'(c))   last[c] <= rx_data;
    end
  end

  assign rd_byte = last[rd_ch];
endmodule

// File: rtl/codec_host_regs.sv
module codec_host_regs
  import chb_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              irq,
  output logic              codec_rst,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [CH_W-1:0]   tx_sel,
  output logic [DATA_W-1:0] tx_data,
  input  logic              rx_valid,
  input  logic [CH_W-1:0]   rx_sel,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              xfer_done
);
  logic              is_chan;
  logic [CH_W-1:0]   chan;
  logic              ready;
  logic [DATA_W-1:0] rx_byte;
  logic [DATA_W-1:0] rd_next;

  assign is_chan = host_addr[ADDR_W-1];
  assign chan    = host_addr[CH_W-1:0];

  chb_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_mask  (host_wr && host_addr == A_STATUS),
    .set_mask  (host_wr && host_addr == A_MASK_SET),
    .pwr_down  (host_wr && host_addr == A_PWR_DOWN),
    .pwr_up    (host_wr && host_addr == A_PWR_UP),
    .ctrl_wr   (host_wr && host_addr == A_CTRL),
    .xfer_done (xfer_done),
    .ready     (ready),
    .irq       (irq),
    .codec_rst (codec_rst)
  );

  chb_tx #(.DATA_W(DATA_W), .CH_N(CH_COUNT)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (host_wr && is_chan),
    .wr_ch    (chan),
    .wr_data  (host_wdata),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .tx_sel   (tx_sel),
    .tx_data  (tx_data)
  );

  chb_rx #(.DATA_W(DATA_W), .CH_N(CH_COUNT)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rx_sel   (rx_sel),
    .rx_data  (rx_data),
    .rd_ch    (chan),
    .rd_byte  (rx_byte)
  );

  always_comb begin
    if (is_chan)                    rd_next = rx_byte;
    else if (host_addr == A_STATUS) rd_next = {ready, {(DATA_W-1){1'b0}}};
    else                            rd_next = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       host_rdata <= '0;
    else if (host_rd) host_rdata <= rd_next;
  end
endmodule

// File: rtl/chb_checker.sv
module chb_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] host_addr,
  input logic       host_wr,
  input logic       host_rd,
  input logic [7:0] host_rdata,
  input logic       irq,
  input logic       codec_rst,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [1:0] tx_sel,
  input logic [7:0] tx_data
);
  a_r3_clear_quiets_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 3'd0) |=> !irq);

  a_r5_down_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 3'd2) |=> codec_rst);

  a_r5_up_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 3'd3) |=> !codec_rst);

  a_r7_ctrl_write_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 3'd6) |=> !irq);

  a_r2_status_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == 3'd0) |=> host_rdata[6:0] == 7'd0);

  a_r6_strobe_addr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr != 3'd0 && !host_addr[2]) |=> host_rdata == 8'd0);

  a_r10_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_sel) && $stable(tx_data)));

  a_r2_rdata_held: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(host_rdata));
endmodule

bind codec_host_regs chb_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_addr  (host_addr),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .host_rdata (host_rdata),
  .irq        (irq),
  .codec_rst  (codec_rst),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .tx_sel     (tx_sel),
  .tx_data    (tx_data)
);

// File: tb/codec_host_regs_test.sv
`timescale 1ns/1ps
module codec_host_regs_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] host_addr = '0;
  logic       host_wr = 1'b0;
  logic       host_rd = 1'b0;
  logic [7:0] host_wdata = '0;
  wire  [7:0] host_rdata;
  wire        irq;
  wire        codec_rst;
  wire        tx_valid;
  logic       tx_ready = 1'b0;
  wire  [1:0] tx_sel;
  wire  [7:0] tx_data;
  logic       rx_valid = 1'b0;
  logic [1:0] rx_sel = '0;
  logic [7:0] rx_data = '0;
  logic       xfer_done = 1'b0;

  always #2.5 clk = ~clk;

  codec_host_regs uut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq(irq), .codec_rst(codec_rst), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_sel(tx_sel), .tx_data(tx_data), .rx_valid(rx_valid), .rx_sel(rx_sel),
    .rx_data(rx_data), .xfer_done(xfer_done)
  );

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;

  bit         m_mask;
  bit         m_ready;
  bit         m_rst;
  logic [7:0] m_rx [4];

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] f_read(input logic [2:0] a);
    if (a[2])       return m_rx[a[1:0]];
    else if (a == 0) return {m_ready, 7'd0};
    else            return 8'd0;
  endfunction

  function automatic string f_tag(input logic [2:0] a);
    if (a[2])       return "R11 channel read";
    else if (a == 0) return "R2 status read";
    else            return "R6 strobe address read";
  endfunction

  // one host/serial cycle, driven just after a rising edge, checked after the next one
  task automatic cyc(input bit wr, input bit rd, input logic [2:0] a, input logic [7:0] d,
                     input bit rv, input logic [1:0] rs, input logic [7:0] rdat, input bit dn);
    logic [7:0] exp_rd;
    host_wr = wr; host_rd = rd; host_addr = a; host_wdata = d;
    rx_valid = rv; rx_sel = rs; rx_data = rdat; xfer_done = dn;
    exp_rd = f_read(a);
    @(posedge clk); #1;
    if (wr) begin
      case (a)
        3'd0: m_mask = 1'b0;
        3'd1: m_mask = 1'b1;
        3'd2: m_rst  = 1'b1;
        3'd3: m_rst  = 1'b0;
        default: ;
      endcase
    end
    if (dn) m_ready = 1'b1;
    if (wr && a == 3'd6) m_ready = 1'b0;
    if (rv) m_rx[rs] = rdat;
    host_wr = 1'b0; host_rd = 1'b0; rx_valid = 1'b0; xfer_done = 1'b0;
    check_eq("R4 irq", irq, m_ready & m_mask);
    check_eq("R5 codec_rst", codec_rst, m_rst);
    if (rd) check_eq(f_tag(a), host_rdata, exp_rd);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    cyc(1'b1, 1'b0, a, d, 1'b0, 2'd0, 8'd0, 1'b0);
  endtask

  task automatic rd_reg(input logic [2:0] a);
    cyc(1'b0, 1'b1, a, 8'd0, 1'b0, 2'd0, 8'd0, 1'b0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    logic [1:0] exp_sel [4];
    logic [7:0] exp_dat [4];
    m_mask = 1'b0; m_ready = 1'b1; m_rst = 1'b1;
    for (int i = 0; i < 4; i++) m_rx[i] = 8'd0;

    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: reset state at the ports
    check_eq("R1 rdata", host_rdata, 8'd0);
    check_eq("R1 irq", irq, 1'b0);
    check_eq("R1 codec_rst", codec_rst, 1'b1);
    check_eq("R1 tx_valid", tx_valid, 1'b0);
    rd_reg(3'd0);
    check_eq("R1 ready flag after reset", host_rdata, 8'h80);
    for (int a = 4; a < 8; a++) rd_reg(3'(a));   // R12: received bytes start at 0

    // R4 / R3: mask set and clear ignore the data byte
    wr_reg(3'd1, 8'h00);
    check_eq("R4 irq after mask set", irq, 1'b1);
    wr_reg(3'd0, 8'hFF);
    check_eq("R3 irq after mask clear", irq, 1'b0);
    wr_reg(3'd1, 8'hA5);

    // R5: power strobes
    wr_reg(3'd3, 8'hFF);
    check_eq("R5 pin low after power up", codec_rst, 1'b0);
    wr_reg(3'd2, 8'h00);
    check_eq("R5 pin high after power down", codec_rst, 1'b1);

    // R7: ready flag clear, set, and collision
    wr_reg(3'd6, 8'h11);
    check_eq("R7 irq after control write", irq, 1'b0);
    rd_reg(3'd0);
    cyc(1'b0, 1'b0, 3'd0, 8'd0, 1'b0, 2'd0, 8'd0, 1'b1);
    check_eq("R7 irq after done", irq, 1'b1);
    cyc(1'b1, 1'b0, 3'd6, 8'h22, 1'b0, 2'd0, 8'd0, 1'b1);
    check_eq("R7 control write beats done", irq, 1'b0);
    cyc(1'b0, 1'b0, 3'd0, 8'd0, 1'b0, 2'd0, 8'd0, 1'b1);

    // R11: receive store, and read in the same cycle as the store
    cyc(1'b0, 1'b0, 3'd0, 8'd0, 1'b1, 2'd2, 8'h3C, 1'b0);
    cyc(1'b0, 1'b1, 3'd6, 8'd0, 1'b1, 2'd2, 8'h4D, 1'b0);
    check_eq("R11 same-cycle read keeps old byte", host_rdata, 8'h3C);
    rd_reg(3'd6);

    // drain the two control bytes queued above
    tx_ready = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    tx_ready = 1'b0;

    // R8 / R9 / R10: queue with the stream stalled
    wr_reg(3'd7, 8'h77);
    wr_reg(3'd6, 8'hC6);
    wr_reg(3'd5, 8'h55);
    wr_reg(3'd4, 8'h44);
    check_eq("R8 first byte valid", tx_valid, 1'b1);
    check_eq("R8 first byte channel", tx_sel, 2'd3);
    check_eq("R8 first byte data", tx_data, 8'h77);
    wr_reg(3'd5, 8'h5A);
    rd_reg(3'd0);
    check_eq("R10 stalled channel", tx_sel, 2'd3);
    check_eq("R10 stalled data", tx_data, 8'h77);

    exp_sel[0] = 2'd3; exp_dat[0] = 8'h77;
    exp_sel[1] = 2'd0; exp_dat[1] = 8'h44;
    exp_sel[2] = 2'd1; exp_dat[2] = 8'h5A;
    exp_sel[3] = 2'd2; exp_dat[3] = 8'hC6;
    tx_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check_eq("R10 back-to-back valid", tx_valid, 1'b1);
      check_eq("R9 order channel", tx_sel, exp_sel[k]);
      check_eq("R8 drained data", tx_data, exp_dat[k]);
    end
    @(negedge clk);
    check_eq("R10 stream empty after drain", tx_valid, 1'b0);
    @(posedge clk); #1;
    tx_ready = 1'b0;

    // random mix against the model
    void'($urandom(32'd20240611));
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      tx_ready = r[30] | r[31];
      cyc(r[2:0] < 3'd3, r[3] | r[4], r[7:5], r[15:8],
          r[16] & r[17], r[19:18], r[27:20], r[28] & r[29]);
    end

    finish_run();
  end
endmodule